// File: doc/BRIEF.md
# Quad-Port Replicated Distributed RAM

This block is a small random-access memory with one write port and four read ports. The default shape is 64 words of 4 bits. The word width and the address width are parameters. The storage is held as four identical copies, one for each read port. Every write is applied to all four copies on the same rising clock edge, so the copies never differ.

Port 0 has a single address. That address selects both the word read on port 0 and the word written when the write enable is high. Ports 1 to 3 are read-only, and each has an independent address. In a single cycle the block can therefore do either of two things: one write plus three independent reads on ports 1 to 3, or four independent reads when nothing is written.

Reads are combinational by default. A build-time parameter adds an output register on every read port, which makes reads synchronous with one cycle of latency. In that mode a read-valid flag shows when the registered outputs carry a real sample. A second parameter builds a half-depth variant, in which the most significant address bit is forced to zero. The memory array has no reset, and a word is undefined until it has been written.

Top module: `quad_port_ram`

## Requirements
- R1: A write happens only on a rising clock edge where `wr_en` is 1, and it stores `wr_data` at the word selected by `addr0`. Edges where `wr_en` is 0 leave every word unchanged, whatever `wr_data` and `addr0` hold.
- R2: A single write updates all four storage copies. After a write, reading that word on any of the four ports returns the same value.
- R3: With `RD_MODE = RD_COMB`, each `rd_dataN` shows the word at its current address in the same cycle, with no clock edge in between.
- R4: With `RD_MODE = RD_REG`, each `rd_dataN` shows, one cycle later, the word its address selected at the previous rising edge. On an edge that also writes that word, the sampled value is the content from before the write.
- R5: Port 0 reads from the same address it writes to. With combinational reads, during a write cycle port 0 shows the old content, and after the edge it shows the written data.
- R6: With combinational reads, if port 1, 2 or 3 addresses the word being written, it shows the old value until the rising edge and the new value after it.
- R7: With no write, the four ports can read four different addresses in the same cycle, and each returns its own word.
- R8: With `SHALLOW = 1`, address bit `ADDR_W-1` is ignored on every port. Addresses `a` and `a + 2**(ADDR_W-1)` select the same word.
- R9: With `RD_MODE = RD_REG`, `rd_valid` is 0 after any rising edge that samples `rst_n` low, and 1 after any rising edge that samples `rst_n` high. With `RD_MODE = RD_COMB`, `rd_valid` equals `rst_n`.
- R10: With `RD_MODE = RD_REG`, a rising edge that samples `rst_n` low clears all four `rd_dataN` to zero. The memory contents are not touched by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and output registers act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset for the output registers and the valid flag |
| wr_en | input | 1 | Write enable for the word at `addr0` |
| addr0 | input | ADDR_W | Shared read/write address of port 0 |
| wr_data | input | DATA_W | Data to be written |
| rd_addr1 | input | ADDR_W | Read address of port 1 |
| rd_addr2 | input | ADDR_W | Read address of port 2 |
| rd_addr3 | input | ADDR_W | Read address of port 3 |
| rd_data0 | output | DATA_W | Read data of port 0 |
| rd_data1 | output | DATA_W | Read data of port 1 |
| rd_data2 | output | DATA_W | Read data of port 2 |
| rd_data3 | output | DATA_W | Read data of port 3 |
| rd_valid | output | 1 | High when the read outputs carry a real sample |

## Verification
The case where two functions meet is a write and a read of the same word in the same cycle. This can happen on port 0, through its shared address, and on ports 1 to 3 when they point at the word being written. The bench provokes it with directed cycles in which every port holds the write address across the write edge and the cycle after it. It also provokes it through random traffic on a narrow address range. Outputs are judged in mid-cycle against a behavioural model: the combinational ports must show the old value before the edge and the new value after it, and the registered ports must show the value from before the write one cycle later.

// File: rtl/qpr_pkg.sv
// Package: shared constants and types for the quad-port replicated RAM.
// Assumes: nothing; holds only compile-time definitions.
package qpr_pkg;

    // Number of read ports, and therefore of storage copies.
    localparam int unsigned NUM_PORTS = 4;

    // Read timing selected at build time.
    typedef enum logic {
        RD_COMB = 1'b0,
        RD_REG  = 1'b1
    } rd_mode_e;

endpackage

// File: rtl/qpr_addr_fold.sv
// Module: qpr_addr_fold
// Maps a port address onto the usable depth. The full-depth build passes the
// address through unchanged. The half-depth build forces the MSB to zero.
// Assumes: ADDR_W >= 2.
module qpr_addr_fold #(
    parameter int unsigned ADDR_W  = 6,
    parameter bit          SHALLOW = 1'b0
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    generate
        if (SHALLOW) begin : g_half
            // Half depth: the top address bit never reaches the storage.
            assign addr_out = {1'b0, addr_in[ADDR_W-2:0]};
        end else begin : g_full
            // Full depth: the address is used as given.
            assign addr_out = addr_in;
        end
    endgenerate

endmodule

// File: rtl/qpr_copy.sv
// Module: qpr_copy
// One storage copy. It has a synchronous write port and one combinational
// read port. The top level drives the same write signals into every copy.
// Assumes: no reset on the array; words are undefined until written.
module qpr_copy #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the write data on the rising edge when enabled.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Combinational read of the selected word.
    assign rd_data = mem[rd_addr];

    // R1: an enabled write lands at its address by the next cycle.
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_addr)] === $past(wr_data));

    // R1: without a write, the word that was read keeps its value.
    a_r1_no_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> mem[$past(rd_addr)] === $past(rd_data));

endmodule

// File: rtl/qpr_out_stage.sv
// Module: qpr_out_stage
// Output register for one read port. It is used only when reads are
// synchronous, and it clears to zero on reset.
// Assumes: the input is the combinational read of a storage copy.
module qpr_out_stage #(
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    // Capture the read word on each edge; clear it during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R4: the registered output is the read word from one cycle before.
    a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> q === $past(d));

    // R10: an edge that samples reset leaves the output at zero.
    a_r10_reset_zero: assert property (@(posedge clk)
        !rst_n |=> q == '0);

endmodule

// File: rtl/quad_port_ram.sv
// Module: quad_port_ram
// Quad-port RAM built from four replicated copies. Port 0 shares its address
// between read and write. Ports 1 to 3 read on their own. Every write goes to
// all copies. Reads are combinational or registered, chosen by RD_MODE.
// Assumes: the user never needs more than one write per cycle.
module quad_port_ram
    import qpr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned DATA_W  = 4,
    parameter bit          SHALLOW = 1'b0,
    parameter rd_mode_e    RD_MODE = RD_COMB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr0,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr1,
    input  logic [ADDR_W-1:0] rd_addr2,
    input  logic [ADDR_W-1:0] rd_addr3,
    output logic [DATA_W-1:0] rd_data0,
    output logic [DATA_W-1:0] rd_data1,
    output logic [DATA_W-1:0] rd_data2,
    output logic [DATA_W-1:0] rd_data3,
    output logic              rd_valid
);

    logic [ADDR_W-1:0] raw_addr [NUM_PORTS];
    logic [ADDR_W-1:0] eff_addr [NUM_PORTS];
    logic [DATA_W-1:0] copy_q   [NUM_PORTS];
    logic [DATA_W-1:0] port_q   [NUM_PORTS];

    // Gather the port addresses into one array.
    assign raw_addr[0] = addr0;
    assign raw_addr[1] = rd_addr1;
    assign raw_addr[2] = rd_addr2;
    assign raw_addr[3] = rd_addr3;

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
            // Fold each address to the usable depth.
            qpr_addr_fold #(
                .ADDR_W  (ADDR_W),
                .SHALLOW (SHALLOW)
            ) u_fold (
                .addr_in  (raw_addr[gp]),
                .addr_out (eff_addr[gp])
            );

            // One copy per port; all copies share the write signals.
            qpr_copy #(
                .ADDR_W (ADDR_W),
                .DATA_W (DATA_W)
            ) u_copy (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (wr_en),
                .wr_addr (eff_addr[0]),
                .wr_data (wr_data),
                .rd_addr (eff_addr[gp]),
                .rd_data (copy_q[gp])
            );

            if (gp > 0) begin : g_agree
                // R2: copies addressed alike return identical data.
                a_r2_copies_agree: assert property (@(posedge clk) disable iff (!rst_n)
                    (eff_addr[gp] == eff_addr[0]) |-> copy_q[gp] === copy_q[0]);
            end
        end

        if (RD_MODE == RD_REG) begin : g_sync
            logic valid_q;

            for (gp = 0; gp < NUM_PORTS; gp++) begin : g_reg
                // Registered read stage for this port.
                qpr_out_stage #(
                    .DATA_W (DATA_W)
                ) u_stage (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .d     (copy_q[gp]),
                    .q     (port_q[gp])
                );
            end

            // Track the one-cycle latency of the registered reads.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q <= 1'b0;
                end else begin
                    valid_q <= 1'b1;
                end
            end
            assign rd_valid = valid_q;

            // R9: valid falls after a reset edge and rises after a running edge.
            a_r9_valid_low: assert property (@(posedge clk)
                !rst_n |=> !rd_valid);
            a_r9_valid_high: assert property (@(posedge clk)
                rst_n |=> rd_valid);
        end else begin : g_async
            for (gp = 0; gp < NUM_PORTS; gp++) begin : g_wire
                // Combinational read goes straight to the port.
                assign port_q[gp] = copy_q[gp];
            end
            // Outputs are valid whenever the block is out of reset.
            assign rd_valid = rst_n;

            // R5: after writing, port 0 at the same address shows the new data.
            a_r5_port0_sees_write: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en ##1 $stable(addr0) |-> rd_data0 === $past(wr_data));
        end
    endgenerate

    // Drive the output ports from the selected read path.
    assign rd_data0 = port_q[0];
    assign rd_data1 = port_q[1];
    assign rd_data2 = port_q[2];
    assign rd_data3 = port_q[3];

endmodule

// File: tb/quad_port_ram_test.sv
// Bench: drives three builds (combinational, registered, half depth) with the
// same stimulus. Each build is compared every cycle against a behavioural model.
module quad_port_ram_test;

    localparam int AW = 6;
    localparam int W  = 4;
    localparam int D  = 1 << AW;
    localparam int DH = D / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] a [4];
    logic [W-1:0]  wd = '0;

    logic [W-1:0] c_q [4];
    logic [W-1:0] r_q [4];
    logic [W-1:0] s_q [4];
    logic         c_v, r_v, s_v;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string req   = "R10";

    always #2 clk = ~clk;

    initial begin
        for (int i = 0; i < 4; i++) a[i] = '0;
    end

    quad_port_ram #(.ADDR_W(AW), .DATA_W(W), .SHALLOW(1'b0), .RD_MODE(qpr_pkg::RD_COMB)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr0(a[0]), .wr_data(wd),
        .rd_addr1(a[1]), .rd_addr2(a[2]), .rd_addr3(a[3]),
        .rd_data0(c_q[0]), .rd_data1(c_q[1]), .rd_data2(c_q[2]), .rd_data3(c_q[3]),
        .rd_valid(c_v));

    quad_port_ram #(.ADDR_W(AW), .DATA_W(W), .SHALLOW(1'b0), .RD_MODE(qpr_pkg::RD_REG)) uut_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr0(a[0]), .wr_data(wd),
        .rd_addr1(a[1]), .rd_addr2(a[2]), .rd_addr3(a[3]),
        .rd_data0(r_q[0]), .rd_data1(r_q[1]), .rd_data2(r_q[2]), .rd_data3(r_q[3]),
        .rd_valid(r_v));

    quad_port_ram #(.ADDR_W(AW), .DATA_W(W), .SHALLOW(1'b1), .RD_MODE(qpr_pkg::RD_COMB)) uut_sh (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr0(a[0]), .wr_data(wd),
        .rd_addr1(a[1]), .rd_addr2(a[2]), .rd_addr3(a[3]),
        .rd_data0(s_q[0]), .rd_data1(s_q[1]), .rd_data2(s_q[2]), .rd_data3(s_q[3]),
        .rd_valid(s_v));

    // Behavioural model: contents, written flags, registered expectations.
    logic [W-1:0] m_full [D];
    bit           k_full [D];
    logic [W-1:0] m_sh   [DH];
    bit           k_sh   [DH];
    logic [W-1:0] e_reg  [4];
    bit           ek_reg [4];
    bit           e_valid = 1'b0;

    initial begin
        for (int i = 0; i < D; i++) k_full[i] = 1'b0;
        for (int i = 0; i < DH; i++) k_sh[i] = 1'b0;
        for (int i = 0; i < 4; i++) begin e_reg[i] = '0; ek_reg[i] = 1'b0; end
    end

    // Model update on every rising edge: sample before write, then write.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 4; p++) begin e_reg[p] = '0; ek_reg[p] = 1'b1; end
            e_valid = 1'b0;
        end else begin
            for (int p = 0; p < 4; p++) begin
                e_reg[p]  = m_full[a[p]];
                ek_reg[p] = k_full[a[p]];
            end
            e_valid = 1'b1;
        end
        if (wr_en) begin
            m_full[a[0]] = wd;
            k_full[a[0]] = 1'b1;
            m_sh[a[0][AW-2:0]] = wd;
            k_sh[a[0][AW-2:0]] = 1'b1;
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Mid-cycle comparison of all three builds against the model.
    always @(negedge clk) begin
        if (!done) begin
            check("R9", "comb rd_valid", int'(c_v), int'(rst_n));
            check("R9", "reg rd_valid", int'(r_v), int'(e_valid));
            for (int p = 0; p < 4; p++) begin
                string tag;
                if (wr_en && p == 0) tag = "R5";
                else if (wr_en && a[p] == a[0]) tag = "R6";
                else tag = req;
                if (rst_n && k_full[a[p]])
                    check(tag, $sformatf("comb port %0d", p), int'(c_q[p]), int'(m_full[a[p]]));
                if (rst_n && k_sh[a[p][AW-2:0]])
                    check("R8", $sformatf("half port %0d", p), int'(s_q[p]), int'(m_sh[a[p][AW-2:0]]));
                if (ek_reg[p])
                    check(e_valid ? "R4" : "R10", $sformatf("reg port %0d", p), int'(r_q[p]), int'(e_reg[p]));
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R10/R9: reset state.
        req = "R10";
        repeat (3) step();
        rst_n = 1'b1;

        // R1/R2: fill every word, all ports pointing at the written word.
        req = "R2";
        for (int i = 0; i < D; i++) begin
            wr_en = 1'b1;
            wd = W'(i * 7 + 3);
            for (int p = 0; p < 4; p++) a[p] = AW'(i);
            step();
        end
        wr_en = 1'b0;
        for (int i = 0; i < D; i += 5) begin
            for (int p = 0; p < 4; p++) a[p] = AW'(i);
            step();
        end

        // R7: four distinct reads per cycle.
        req = "R7";
        for (int i = 0; i < 40; i++) begin
            for (int p = 0; p < 4; p++) a[p] = AW'(i + p * 16);
            step();
        end

        // R1: disabled write with changing data leaves contents alone.
        req = "R1";
        for (int i = 0; i < 12; i++) begin
            wr_en = 1'b0;
            wd = W'(~(i * 7 + 3));
            for (int p = 0; p < 4; p++) a[p] = AW'(i);
            step();
        end

        // R5/R6: write word 10 with every port on it, then hold one cycle.
        req = "R3";
        for (int p = 0; p < 4; p++) a[p] = AW'(10);
        wr_en = 1'b1; wd = 4'hA; step();
        wr_en = 1'b0; wd = 4'h0; step();
        wr_en = 1'b1; wd = 4'h5; step();
        wr_en = 1'b0; step();

        // R8: aliasing pair in the half-depth build.
        req = "R8";
        wr_en = 1'b1; a[0] = AW'(5);  wd = 4'h3; step();
        wr_en = 1'b1; a[0] = AW'(37); wd = 4'hC; step();
        wr_en = 1'b0;
        a[0] = AW'(5); a[1] = AW'(37); a[2] = AW'(5); a[3] = AW'(37);
        step();
        step();

        // R3: random mixed traffic on a narrow range to force collisions.
        req = "R3";
        for (int i = 0; i < 400; i++) begin
            wr_en = 1'($urandom_range(0, 1));
            wd = W'($urandom);
            for (int p = 0; p < 4; p++) a[p] = AW'($urandom_range(0, 7) + ((i & 1) ? 32 : 0));
            step();
        end
        wr_en = 1'b0;

        // R9/R10: second reset, contents must survive.
        req = "R10";
        rst_n = 1'b0;
        repeat (2) step();
        rst_n = 1'b1;
        req = "R3";
        for (int i = 0; i < 16; i++) begin
            for (int p = 0; p < 4; p++) a[p] = AW'(i * 4 + p);
            step();
        end

        finish_run();
    end

endmodule